// File: doc/BRIEF.md
# Four-segment commutator for a multipath-delay FFT pipeline

This block sits between two stages of a parallel-pipelined FFT. A block of `4*SEG` samples streams in one sample per enabled cycle as four equal segments, called A, B, C and D here. The block sends them out in the order A, C, B, D, so the next butterfly stage sees the pairing it needs. With the default `SEG = 2` a block is one 8-point radix-2 frame.

A 2-bit phase code tracks which input segment is arriving. A segment-length counter steps that code, and a start strobe forces it back to segment A. The phase code picks the output source. A segment-deep delay line brings A and D out one segment late. C goes straight through. A segment-deep first-in first-out holding buffer parks B until the D phase.

The `en` input marks cycles that carry a sample. When `en` is low the stage is frozen, in the same way a gated clock would freeze it. Blocks may follow each other with no gap. The D segment of one block leaves while the A segment of the next block arrives.

Top module: `mdc_shuffle4`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `out_valid` is 0.
- R2: Within each block, the `4*SEG` valid outputs carry the input samples in segment order A, C, B, D, and each segment keeps its internal sample order. The phase code that selects the output source follows the input segment: 00 (A) emits the delayed D of the previous block, 01 (B) emits delayed A while B is parked, 10 (C) passes the input through, and 11 (D) emits the parked B.
- R3: Count the enabled edge that captures the first A sample as edge 0. Output k of the block (k from 0 to `4*SEG-1`, in A, C, B, D order) is registered at enabled edge `SEG+k`.
- R4: When blocks follow each other with no gap, `out_valid` stays high in every enabled cycle from the first output of the first block to the last output of the last block.
- R5: A cycle with `en` low changes no internal state. After such an edge, `out_valid` is 0 and `out_data` keeps its previous value.
- R6: `sop` sampled high with `en` marks that sample as the first A sample, whatever phase the counter was in.
- R7: `out_valid` is 0 in every cycle that emits no sample of a started block. This covers idle cycles before the first `sop` and after the last D segment has drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Sample present / stage enable |
| sop | input | 1 | First sample of a block (segment A) |
| in_data | input | DATA_W | Input sample |
| out_valid | output | 1 | Output sample valid |
| out_data | output | DATA_W | Reordered output sample |

## Verification
Each result is due at a known enabled edge. The k-th output of a block is due `SEG+k` enabled edges after the edge that took in the first A sample. The scoreboard therefore tags every expected sample with that edge number, and edges with `en` low do not advance the count. The monitor samples on the falling edge. It requires the valid sample to arrive exactly at the tagged edge with the expected data, and it flags any valid output that has no expected sample waiting. After every disabled edge it checks that `out_valid` is low and `out_data` has not moved.

// File: rtl/mdc_pkg.sv
package mdc_pkg;
    typedef enum logic [1:0] {
        SEG_A = 2'b00,
        SEG_B = 2'b01,
        SEG_C = 2'b10,
        SEG_D = 2'b11
    } seg_phase_e;
endpackage

// File: rtl/mdc_phase_ctr.sv
module mdc_phase_ctr
    import mdc_pkg::*;
#(
    parameter int SEG = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       sop,
    output seg_phase_e phase,
    output logic       seg_last
);
    localparam int CW = (SEG > 2) ? $clog2(SEG) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        seg_phase_e    ph;
    } ctr_t;

    ctr_t          st_d, st_q;
    logic [CW-1:0] cur_cnt;
    logic [1:0]    nxt_ph;

    always_comb begin
        // a start strobe makes this sample index 0 of segment A
        phase    = sop ? SEG_A : st_q.ph;
        cur_cnt  = sop ? '0 : st_q.cnt;
        seg_last = (cur_cnt == CW'(SEG - 1));
        nxt_ph   = phase + 2'd1;
        st_d     = st_q;
        if (en) begin
            if (seg_last) begin
                st_d.cnt = '0;
                st_d.ph  = seg_phase_e'(nxt_ph);
            end else begin
                st_d.cnt = cur_cnt + CW'(1);
                st_d.ph  = phase;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, ph: SEG_A};
        end else begin
            st_q <= st_d;
        end
    end

    // R6: a start strobe realigns the counter to the second sample of A
    assert_sop_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sop) |=> (st_q.ph == SEG_A && st_q.cnt == CW'(1)));

    // R5: a disabled cycle leaves the counter untouched
    assert_ctr_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(st_q.cnt) && $stable(st_q.ph)));
endmodule

// File: rtl/mdc_seg_line.sv
module mdc_seg_line #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DEPTH-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (shift) begin
            mem_d[0] = din;
            for (int i = 1; i < DEPTH; i++) begin
                mem_d[i] = mem_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign dout = mem_q[DEPTH-1];
endmodule

// File: rtl/mdc_shuffle4.sv
module mdc_shuffle4
    import mdc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int SEG    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sop,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    typedef struct packed {
        logic              live;
        logic              tail;
        logic              vld;
        logic [DATA_W-1:0] data;
    } shuf_t;

    shuf_t             st_d, st_q;
    seg_phase_e        phase;
    logic              seg_last;
    logic              park_shift;
    logic              sel_vld;
    logic [DATA_W-1:0] late_out, park_out, sel_data;

    mdc_phase_ctr #(.SEG(SEG)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .sop      (sop),
        .phase    (phase),
        .seg_last (seg_last)
    );

    // every sample runs through the one-segment delay line
    mdc_seg_line #(.DATA_W(DATA_W), .DEPTH(SEG)) u_late (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (en),
        .din   (in_data),
        .dout  (late_out)
    );

    // the holding buffer takes B in and gives it out during D
    mdc_seg_line #(.DATA_W(DATA_W), .DEPTH(SEG)) u_park (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (park_shift),
        .din   (in_data),
        .dout  (park_out)
    );

    always_comb begin
        park_shift = en && (phase == SEG_B || phase == SEG_D);
        unique case (phase)
            SEG_A:   begin sel_data = late_out; sel_vld = st_q.tail; end
            SEG_B:   begin sel_data = late_out; sel_vld = st_q.live; end
            SEG_C:   begin sel_data = in_data;  sel_vld = st_q.live; end
            default: begin sel_data = park_out; sel_vld = st_q.live; end
        endcase

        st_d     = st_q;
        st_d.vld = 1'b0;
        if (en) begin
            st_d.vld  = sel_vld;
            st_d.data = sel_data;
            if (sop) begin
                st_d.live = 1'b1;
            end else if (phase == SEG_D && seg_last) begin
                st_d.live = 1'b0;
            end
            if (phase == SEG_D && seg_last && st_q.live) begin
                st_d.tail = 1'b1;
            end else if (phase == SEG_A && seg_last) begin
                st_d.tail = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;

    // R2: during a live C segment the input reaches the output one edge later
    assert_c_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !sop && phase == SEG_C && st_q.live) |=> (out_valid && out_data == $past(in_data)));

    // R5: a frozen edge drops valid and holds the data
    assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!out_valid && $stable(out_data)));

    // R7: an A-phase cycle with nothing left to drain emits nothing
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && phase == SEG_A && !st_q.tail) |=> !out_valid);

    // R1: output valid is low straight after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

// File: tb/mdc_shuffle4_bench.sv
module mdc_shuffle4_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 16;
    localparam int SEG        = 4;
    localparam int BLK        = 4 * SEG;

    typedef struct {
        logic [DATA_W-1:0] data;
        int                tag;
        string             req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic              sop = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;

    exp_t              q[$];
    int                ecnt = 0;
    logic              last_en = 1'b0;
    logic              mon_on = 1'b0;
    logic [DATA_W-1:0] prev_data = '0;
    int                total = 0;
    int                bad = 0;
    bit                finished = 1'b0;

    mdc_shuffle4 #(.DATA_W(DATA_W), .SEG(SEG)) u_mdc_shuffle4 (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .sop       (sop),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        if (en) ecnt <= ecnt + 1;
        last_en <= en;
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (mon_on) begin
            if (!last_en) begin
                total++;
                if (out_valid !== 1'b0 || out_data !== prev_data) begin
                    bad++;
                    $display("FAIL R5: frozen edge valid=%0b data=%h, expected valid=0 data=%h",
                             out_valid, out_data, prev_data);
                end
            end else if (out_valid) begin
                total++;
                if (q.size() == 0) begin
                    bad++;
                    $display("FAIL R7: valid with nothing due, data=%h, expected valid=0", out_data);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (e.tag != ecnt) begin
                        bad++;
                        $display("FAIL R3: output at edge %0d, expected edge %0d", ecnt, e.tag);
                    end else if (out_data !== e.data) begin
                        bad++;
                        $display("FAIL %s: data=%h, expected %h", e.req, out_data, e.data);
                    end
                end
            end else if (q.size() != 0 && q[0].tag <= ecnt) begin
                exp_t e;
                e = q.pop_front();
                total++;
                bad++;
                $display("FAIL R4: no valid at edge %0d, expected data %h", ecnt, e.data);
            end
            prev_data = out_data;
        end
    end

    task automatic send_block(input bit with_sop, input int gap_at, input string req);
        logic [DATA_W-1:0] d[BLK];
        int                e0;
        int                k;
        int                order[4] = '{0, 2, 1, 3};
        for (int j = 0; j < BLK; j++) d[j] = DATA_W'($urandom);
        k = 0;
        for (int j = 0; j < BLK; j++) begin
            @(negedge clk);
            if (j == gap_at) begin
                en  = 1'b0;
                sop = 1'b0;
                @(negedge clk);
            end
            if (j == 0) begin
                e0 = ecnt;
                foreach (order[s]) begin
                    for (int i = 0; i < SEG; i++) begin
                        q.push_back('{d[order[s]*SEG+i], e0 + SEG + k + 1, req});
                        k++;
                    end
                end
            end
            en      = 1'b1;
            sop     = with_sop && (j == 0);
            in_data = d[j];
        end
    endtask

    task automatic idle(input int n, input bit enabled);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            en      = enabled;
            sop     = 1'b0;
            in_data = DATA_W'($urandom);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        total++;
        if (out_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1: out_valid=%b during reset, expected 0", out_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1: out_valid=%b after reset, expected 0", out_valid);
        end
        mon_on = 1'b1;
        // R7: idle enabled cycles before any start must stay quiet
        idle(7, 1'b1);
        // R6: start while the counter sits mid-segment
        send_block(1'b1, -1, "R6");
        // R2/R4: back-to-back blocks of random data
        for (int b = 0; b < 6; b++) send_block(1'b1, -1, "R2");
        // R5: freeze inside a block, then continue
        send_block(1'b1, 6, "R5");
        send_block(1'b1, 2 * SEG + 1, "R5");
        send_block(1'b1, -1, "R4");
        idle(2 * BLK, 1'b1);
        idle(3, 1'b0);
        idle(5, 1'b1);
        // R6: another misaligned start after the drain
        send_block(1'b1, -1, "R6");
        send_block(1'b1, -1, "R2");
        idle(2 * BLK, 1'b1);
        @(negedge clk);
        while (q.size() != 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            bad++;
            $display("FAIL R4: never emitted, data=%h expected at edge %0d", e.data, e.tag);
        end
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end
endmodule